// File: doc/BRIEF.md
# Ridge Orientation Peak Search

This block picks the dominant ridge direction of one image block out of 16 quantized orientations. It does not do the transform arithmetic itself. It asks an external transform engine for one orientation at a time. The engine answers with a signed sine sum and a signed cosine sum for each of four frequencies. The block squares and adds those into a resonance energy and keeps the result in a per-block cache, so that no orientation is fetched twice.

The search is a hill climb around the circle of orientations. It starts from the direction solved for the previous block, or from orientation 0 when there is no previous result. It stops at the first candidate whose energy is a strict circular local maximum and is also above a programmable threshold. If sixteen candidates fail the test, the block reports "no direction". A start pulse launches one block search. A single-cycle valid strobe returns the answer.

Top module: `ridge_peak_search`

## Requirements
- R1: After reset, `outValid` and `reqValid` are low and stay low until `start` is pulsed.
- R2: The energy of an orientation is the sum, over the 4 frequencies, of sin² + cos². Each response term is a signed two's-complement field of SUM_W bits, and frequency f sits at bits [f*SUM_W +: SUM_W] of `respSin` and `respCos`. The energy is compared unsigned against the 32-bit `threshold` with no loss of precision.
- R3: A candidate c is accepted when E(c) is strictly greater than E(c-1), E(c+1) and `threshold`. Indices wrap, so the predecessor of 0 is 15 and the successor of 15 is 0.
- R4: With `seedValid`=1 at `start`, the first candidate is `seedDir`, and the first three orientations requested are seedDir-1, seedDir and seedDir+1, in that order.
- R5: With `seedValid`=0 at `start`, the first candidate is 0, so the first requests are 15, 0 and 1.
- R6: When the first candidate is rejected, the walk direction is set to up if E(c+1) > E(c-1), and to down otherwise (ties go down). The direction then stays fixed for the rest of the block. For each new candidate, only the uncached members of c-1, c, c+1 are requested, in that order.
- R7: Within one block no orientation is requested twice. A `start` clears the cache, so the next block requests its orientations afresh.
- R8: If 16 candidates have been rejected, the block reports `outNone`=1 with `outDir`=0.
- R9: `outValid` is high for exactly one cycle per block. `outDir` and `outNone` carry the result in that cycle.
- R10: `reqValid` stays high with a stable `reqDir` until a cycle in which `respValid` is high. The response fields are taken in that cycle, and the next request comes no earlier than the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a block search (taken while idle) |
| seedValid | input | 1 | Previous-block direction is available |
| seedDir | input | 4 | Previous-block direction |
| threshold | input | 32 | Minimum energy for acceptance (exclusive) |
| reqValid | output | 1 | Request to the transform engine |
| reqDir | output | 4 | Orientation being requested |
| respValid | input | 1 | Engine response strobe |
| respSin | input | 4*SUM_W | Signed sine sums, one field per frequency |
| respCos | input | 4*SUM_W | Signed cosine sums, one field per frequency |
| outValid | output | 1 | Result strobe, one cycle |
| outDir | output | 4 | Chosen orientation (0 when none) |
| outNone | output | 1 | No orientation passed the test |

## Verification
The bench aims at the wrap points 15/0. A design with plain rather than circular neighbour indexing would compare against the wrong orientation there and pick or request the wrong index. It sets an energy exactly equal to the threshold, and then one above it, using mixed-sign sine and cosine terms. A non-strict compare or a truncated energy would flip that decision. Flat energy profiles make sure that equality is never taken as a peak and that the search ends with "no direction" after sixteen candidates instead of looping. Repeated blocks and random profiles check the exact request sequence. A design that re-fetched cached orientations, walked the wrong way on ties, or kept a stale cache across a start would produce a request list that differs from the model.

// File: rtl/ridge_pkg.sv
package ridge_pkg;
  localparam int DIRS  = 16;
  localparam int DIR_W = $clog2(DIRS);

  typedef logic [DIR_W-1:0] dir_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic write;
    dir_t wrIdx;
    dir_t cand;
  } dpCtl_t;
endpackage

// File: rtl/ridge_energy_dp.sv
module ridge_energy_dp
  import ridge_pkg::*;
#(
  parameter int NUM_FREQ = 4,
  parameter int SUM_W    = 20,
  parameter int THR_W    = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpCtl_t                    ctl,
  input  logic [NUM_FREQ*SUM_W-1:0] respSin,
  input  logic [NUM_FREQ*SUM_W-1:0] respCos,
  input  logic [THR_W-1:0]          threshold,
  output logic                      needFetch,
  output dir_t                      fetchIdx,
  output logic                      isPeak,
  output logic                      upWins
);
  localparam int SQ_W     = 2 * SUM_W;
  localparam int ENERGY_W = SQ_W + $clog2(2 * NUM_FREQ) + 1;

  logic [SQ_W-1:0]     sinSq [NUM_FREQ];
  logic [SQ_W-1:0]     cosSq [NUM_FREQ];
  logic [ENERGY_W-1:0] respEnergy;

  genvar f;
  generate
    for (f = 0; f < NUM_FREQ; f++) begin : g_sq
      logic signed [SQ_W-1:0] sExt, cExt;
      assign sExt = SQ_W'(signed'(respSin[f*SUM_W +: SUM_W]));
      assign cExt = SQ_W'(signed'(respCos[f*SUM_W +: SUM_W]));
      assign sinSq[f] = unsigned'(sExt * sExt);
      assign cosSq[f] = unsigned'(cExt * cExt);
    end
  endgenerate

  always_comb begin
    respEnergy = '0;
    for (int k = 0; k < NUM_FREQ; k++) begin
      respEnergy = respEnergy + ENERGY_W'(sinSq[k]) + ENERGY_W'(cosSq[k]);
    end
  end

  // energy cache, one entry per orientation
  logic [ENERGY_W-1:0] eTab [DIRS];
  logic [DIRS-1:0]     have;

  always_ff @(posedge clk) begin
    if (!rstN)          have <= '0;
    else if (ctl.clear) have <= '0;
    else if (ctl.write) have[ctl.wrIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ctl.write) eTab[ctl.wrIdx] <= respEnergy;
  end

  dir_t candM, candP;
  logic [ENERGY_W-1:0] eM, eC, eP, thrExt;

  assign candM  = ctl.cand - dir_t'(1);
  assign candP  = ctl.cand + dir_t'(1);
  assign eM     = eTab[candM];
  assign eC     = eTab[ctl.cand];
  assign eP     = eTab[candP];
  assign thrExt = ENERGY_W'(threshold);

  always_comb begin
    needFetch = 1'b1;
    fetchIdx  = candM;
    if (!have[candM])         fetchIdx = candM;
    else if (!have[ctl.cand]) fetchIdx = ctl.cand;
    else if (!have[candP])    fetchIdx = candP;
    else                      needFetch = 1'b0;
  end

  assign isPeak = (eC > eM) && (eC > eP) && (eC > thrExt);
  assign upWins = (eP > eM);

  // R7
  no_refetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.write |-> !have[ctl.wrIdx]);

  // R7
  cache_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clear |=> (have == '0));
endmodule

// File: rtl/ridge_search_ctl.sv
module ridge_search_ctl
  import ridge_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   seedValid,
  input  dir_t   seedDir,
  input  logic   respValid,
  input  logic   needFetch,
  input  dir_t   fetchIdx,
  input  logic   isPeak,
  input  logic   upWins,
  output dpCtl_t ctl,
  output logic   reqValid,
  output dir_t   reqDir,
  output logic   outValid,
  output dir_t   outDir,
  output logic   outNone
);
  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_FETCH} state_t;

  state_t state;
  dir_t   cand;
  dir_t   reqIdx;
  dir_t   visits;
  logic   stepSet;
  logic   stepUp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cand     <= '0;
      reqIdx   <= '0;
      visits   <= '0;
      stepSet  <= 1'b0;
      stepUp   <= 1'b0;
      outValid <= 1'b0;
      outDir   <= '0;
      outNone  <= 1'b0;
    end else begin
      outValid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            cand    <= seedValid ? seedDir : '0;
            visits  <= '0;
            stepSet <= 1'b0;
            state   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (needFetch) begin
            reqIdx <= fetchIdx;
            state  <= ST_FETCH;
          end else if (isPeak) begin
            outValid <= 1'b1;
            outDir   <= cand;
            outNone  <= 1'b0;
            state    <= ST_IDLE;
          end else if (visits == dir_t'(DIRS - 1)) begin
            outValid <= 1'b1;
            outDir   <= '0;
            outNone  <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            visits <= visits + dir_t'(1);
            if (!stepSet) begin
              stepSet <= 1'b1;
              stepUp  <= upWins;
              cand    <= upWins ? cand + dir_t'(1) : cand - dir_t'(1);
            end else begin
              cand    <= stepUp ? cand + dir_t'(1) : cand - dir_t'(1);
            end
          end
        end
        ST_FETCH: begin
          if (respValid) state <= ST_CHECK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqValid  = (state == ST_FETCH);
  assign reqDir    = reqIdx;
  assign ctl.clear = (state == ST_IDLE) && start;
  assign ctl.write = (state == ST_FETCH) && respValid;
  assign ctl.wrIdx = reqIdx;
  assign ctl.cand  = cand;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !respValid) |=> (reqValid && $stable(reqDir)));

  // R10
  req_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && respValid) |=> !reqValid);

  // R9
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R8
  none_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outNone) |-> (outDir == '0));
endmodule

// File: rtl/ridge_peak_search.sv
module ridge_peak_search
  import ridge_pkg::*;
#(
  parameter int NUM_FREQ = 4,
  parameter int SUM_W    = 20,
  parameter int THR_W    = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic                      seedValid,
  input  logic [DIR_W-1:0]          seedDir,
  input  logic [THR_W-1:0]          threshold,
  output logic                      reqValid,
  output logic [DIR_W-1:0]          reqDir,
  input  logic                      respValid,
  input  logic [NUM_FREQ*SUM_W-1:0] respSin,
  input  logic [NUM_FREQ*SUM_W-1:0] respCos,
  output logic                      outValid,
  output logic [DIR_W-1:0]          outDir,
  output logic                      outNone
);
  dpCtl_t ctl;
  logic   needFetch, isPeak, upWins;
  dir_t   fetchIdx;

  ridge_search_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .seedValid(seedValid),
    .seedDir(seedDir), .respValid(respValid), .needFetch(needFetch),
    .fetchIdx(fetchIdx), .isPeak(isPeak), .upWins(upWins), .ctl(ctl),
    .reqValid(reqValid), .reqDir(reqDir), .outValid(outValid),
    .outDir(outDir), .outNone(outNone)
  );

  ridge_energy_dp #(.NUM_FREQ(NUM_FREQ), .SUM_W(SUM_W), .THR_W(THR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .respSin(respSin), .respCos(respCos),
    .threshold(threshold), .needFetch(needFetch), .fetchIdx(fetchIdx),
    .isPeak(isPeak), .upWins(upWins)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!rstN) && !start) |-> (!outValid && !reqValid));
endmodule

// File: tb/ridge_peak_search_bench.sv
module ridge_peak_search_bench;
  localparam int NF = 4;
  localparam int SW = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, seedValid = 1'b0, respValid = 1'b0;
  logic [3:0] seedDir = '0;
  logic [31:0] threshold = '0;
  logic [NF*SW-1:0] respSin = '0, respCos = '0;
  logic reqValid, outValid, outNone;
  logic [3:0] reqDir, outDir;

  ridge_peak_search u_ridge_peak_search (
    .clk(clk), .rstN(rstN), .start(start), .seedValid(seedValid),
    .seedDir(seedDir), .threshold(threshold), .reqValid(reqValid),
    .reqDir(reqDir), .respValid(respValid), .respSin(respSin),
    .respCos(respCos), .outValid(outValid), .outDir(outDir), .outNone(outNone)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 0;

  int sv [16][NF];
  int cv [16][NF];
  longint en [16];
  int expReq [32];
  int expN;
  int gotReq [32];
  int gotN;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic calcEnergy();
    for (int d = 0; d < 16; d++) begin
      en[d] = 0;
      for (int f = 0; f < NF; f++)
        en[d] += longint'(sv[d][f]) * sv[d][f] + longint'(cv[d][f]) * cv[d][f];
    end
  endtask

  // simple profile: one sine term per orientation
  task automatic setAmps(input int amp [16]);
    for (int d = 0; d < 16; d++)
      for (int f = 0; f < NF; f++) begin
        sv[d][f] = (f == 0) ? amp[d] : 0;
        cv[d][f] = 0;
      end
  endtask

  task automatic model(input bit sV, input int sD, input longint thr,
                       output int eDir, output bit eNone);
    bit got [16];
    int c, visits, k;
    bit stepSet, up;
    longint eM, eC, eP;
    foreach (got[i]) got[i] = 0;
    expN = 0; c = sV ? sD : 0; visits = 0; stepSet = 0; up = 0;
    eDir = 0; eNone = 0;
    forever begin
      for (int j = -1; j <= 1; j++) begin
        k = (c + j + 16) % 16;
        if (!got[k]) begin got[k] = 1; expReq[expN] = k; expN++; end
      end
      eM = en[(c + 15) % 16]; eC = en[c]; eP = en[(c + 1) % 16];
      if (eC > eM && eC > eP && eC > thr) begin eDir = c; return; end
      visits++;
      if (visits == 16) begin eNone = 1; eDir = 0; return; end
      if (!stepSet) begin stepSet = 1; up = (eP > eM); end
      c = up ? (c + 1) % 16 : (c + 15) % 16;
    end
  endtask

  task automatic runBlock(input bit sV, input int sD, input longint thr,
                          input string tag);
    int eDir, lat, cyc;
    bit eNone, seen, seqOk;
    calcEnergy();
    model(sV, sD, thr, eDir, eNone);
    @(negedge clk);
    start = 1; seedValid = sV; seedDir = 4'(sD); threshold = 32'(thr);
    @(negedge clk);
    start = 0;
    gotN = 0; seen = 0; cyc = 0;
    while (!seen && cyc < 400) begin
      cyc++;
      if (outValid) begin
        seen = 1;
        // R8 R3 result
        chk(outDir == 4'(eDir), "R3", {tag, " dir"}, outDir, eDir);
        chk(outNone == eNone, "R8", {tag, " none"}, outNone, eNone);
        @(negedge clk);
        // R9
        chk(!outValid, "R9", {tag, " pulse width"}, outValid, 0);
      end else if (reqValid) begin
        if (gotN < 32) gotReq[gotN] = reqDir;
        gotN++;
        lat = $urandom_range(0, 2);
        for (int w = 0; w < lat; w++) begin
          @(negedge clk);
          // R10
          chk(reqValid && reqDir == 4'(gotReq[gotN-1]), "R10", {tag, " hold"},
              reqDir, gotReq[gotN-1]);
        end
        for (int f = 0; f < NF; f++) begin
          respSin[f*SW +: SW] = SW'(sv[reqDir][f]);
          respCos[f*SW +: SW] = SW'(cv[reqDir][f]);
        end
        respValid = 1;
        @(negedge clk);
        respValid = 0;
      end else begin
        @(negedge clk);
      end
    end
    chk(seen, "R9", {tag, " result seen"}, seen, 1);
    // R4 R5 R6 R7: exact request sequence
    seqOk = (gotN == expN);
    for (int i = 0; i < expN && i < gotN && i < 32; i++)
      if (gotReq[i] != expReq[i]) seqOk = 0;
    chk(seqOk, "R7", {tag, " request sequence/count"}, gotN, expN);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int amp [16];
    int base;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!outValid && !reqValid, "R1", "during reset", {outValid, reqValid}, 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    chk(!outValid && !reqValid, "R1", "idle after reset", {outValid, reqValid}, 0);

    // R4: seeded, peak at seed 5
    foreach (amp[i]) amp[i] = (i == 5) ? 10000 : 5000;
    setAmps(amp);
    runBlock(1, 5, 27000000, "R4 seeded peak");
    chk(gotN >= 3 && gotReq[0] == 4 && gotReq[1] == 5 && gotReq[2] == 6,
        "R4", "first three requests", gotReq[0], 4);

    // R5 and R3 wrap: no seed, peak at 0
    foreach (amp[i]) amp[i] = (i == 0) ? 10000 : 5000;
    setAmps(amp);
    runBlock(0, 9, 27000000, "R5 unseeded");
    chk(gotN >= 3 && gotReq[0] == 15 && gotReq[1] == 0 && gotReq[2] == 1,
        "R5", "first three requests", gotReq[0], 15);

    // R3 wrap: peak at 15, seed 0, climb down
    foreach (amp[i]) amp[i] = (i == 15) ? 12000 : ((i == 0) ? 9000 : 5000);
    setAmps(amp);
    runBlock(1, 0, 27000000, "R3 wrap 15");

    // R6: ramp toward 9 from seed 3
    foreach (amp[i]) begin
      base = (i > 9) ? i - 9 : 9 - i;
      if (base > 8) base = 16 - base;
      amp[i] = 12000 - 900 * base;
    end
    setAmps(amp);
    runBlock(1, 3, 27000000, "R6 climb up");
    // R6: tie neighbours -> go down
    foreach (amp[i]) amp[i] = 4000;
    amp[6] = 6000; amp[10] = 9000;
    setAmps(amp);
    runBlock(1, 8, 1000, "R6 tie down");

    // R8: flat profile, nothing strict
    foreach (amp[i]) amp[i] = 8000;
    setAmps(amp);
    runBlock(1, 7, 1000, "R8 flat");

    // R2: mixed-sign terms, energy exactly 36e6 at orientation 7
    foreach (amp[i]) amp[i] = 1000;
    setAmps(amp);
    sv[7][0] = 3000; sv[7][2] = -3000; cv[7][1] = 3000; cv[7][3] = -3000;
    runBlock(1, 7, 36000000, "R2 equal threshold");
    chk(outNone == 1'b1, "R2", "energy equal to threshold rejected", outNone, 1);
    runBlock(1, 7, 35999999, "R2 above threshold");
    chk(outNone == 1'b0 && outDir == 4'd7, "R2", "energy above threshold", outDir, 7);
    // R7: identical block again must refetch after start clears the cache
    runBlock(1, 7, 35999999, "R7 repeat block");

    // random profiles
    for (int b = 0; b < 60; b++) begin
      for (int d = 0; d < 16; d++)
        for (int f = 0; f < NF; f++) begin
          if (b % 3 == 0) begin
            sv[d][f] = int'($urandom_range(0, 4)) * 2000 - 4000;
            cv[d][f] = 0;
          end else begin
            sv[d][f] = int'($urandom_range(0, 2 * 524287)) - 524287;
            cv[d][f] = int'($urandom_range(0, 2 * 524287)) - 524287;
          end
        end
      runBlock($urandom_range(0, 1) == 1, int'($urandom_range(0, 15)),
               longint'($urandom_range(0, 32'h7fffffff)) >> ($urandom_range(0, 8)),
               "R6 random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule